// File: doc/BRIEF.md
# CAN Receive Error and Interrupt Flag Unit

This unit sits beside a CAN frame sequencer and watches each received bus bit together with a field code that the sequencer supplies. It applies four receive checks: the bit-stuffing run rule, the CRC-15 check, fixed-value checks on delimiter and end-of-frame bits, and presence of a dominant acknowledge. Each failed check latches a sticky flag in an 8-bit status byte.

Two more sticky flags record the wrap of an external 16-bit CAN timer and a full receive buffer. Bit 7 of the byte summarises every enabled source and also drives the interrupt request, so software can either take the interrupt or poll the byte. Software clears individual flags by writing zeros through a one-cycle register port. Dominant is logic 0 and recessive is logic 1.

Top module: `can_err_irq_unit`

## Requirements
- R1: The status byte reads as {bit7 summary, bit6 reserved, bit5 timer wrap, bit4 buffer full, bit3 stuff error, bit2 CRC error, bit1 form error, bit0 acknowledge error}. After reset every bit reads 0, and bit 6 always reads 0 whatever is written.
- R2: A write with `reg_wr` high clears each of bits 5..0 whose `reg_wdata` bit is 0 and leaves bits written as 1 unchanged. A hardware set in the same cycle as a clear wins.
- R3: Bit 5 sets one clock edge after `can_timer` moves from 0xFFFF to 0x0000 between consecutive cycles. No other change of `can_timer` sets it.
- R4: A set bit 5 contributes to bit 7 and `irq` only while `tmr_irq_en` is 1.
- R5: Bit 4 sets at any clock edge where `buf_full` is 1 and stays set after `buf_full` falls.
- R6: Field codes are 0 idle, 1 start of frame, 2 frame body, 3 CRC sequence, 4 CRC delimiter, 5 acknowledge slot, 6 acknowledge delimiter and 7 end of frame. Only bits with `bit_valid` high are examined. Bit 3 sets on the sixth consecutive equal-valued bit in fields 1 to 3, stuff bits included. Field 1 restarts the run count.
- R7: CRC-15 with polynomial 0x4599 and a zero start value runs over the non-stuff bits of fields 1 to 3. Bit 2 sets at the CRC-delimiter bit if the remainder is not zero.
- R8: Bit 1 sets when a bit in field 4, 6 or 7 is dominant.
- R9: Bit 0 sets when the bit in field 5 is recessive.
- R10: Bit 7 and `irq` are 1 exactly when any of bits 4..0 is set, or bit 5 is set with `tmr_irq_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Strobe: `rx_bit` holds a new bus bit |
| rx_bit | input | 1 | Received bus bit, 0 dominant |
| stuff_slot | input | 1 | Marks the current bit as a stuff bit |
| fld_code | input | 3 | Frame field of the current bit (R6 encoding) |
| can_timer | input | 16 | Free-running CAN timer value |
| buf_full | input | 1 | Receive buffer full indication |
| tmr_irq_en | input | 1 | Enables timer wrap as an interrupt source |
| reg_wr | input | 1 | Status byte write strobe |
| reg_wdata | input | 8 | Write data, 0 clears a flag |
| reg_rdata | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |

## Verification
Each of the six flags is due at the first rising edge that samples its cause: the offending strobed bit, the cycle in which `can_timer` reads 0x0000 after 0xFFFF, or a high `buf_full`. The summary bit and `irq` follow the flags and `tmr_irq_en` with no register in between. The bench changes inputs on falling edges and reads results on the falling edge after the capturing rising edge. For whole frames this is the falling edge after the last end-of-frame bit, and for the enable it is the same half cycle.

// File: rtl/can_flag_pkg.sv
package can_flag_pkg;

    localparam int CRC_W = 15;
    localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;
    localparam int FLAG_N = 6;
    localparam int STAT_W = 8;
    localparam int BIT_SUM = 7;

    typedef enum logic [2:0] {
        FLD_IDLE    = 3'd0,
        FLD_SOF     = 3'd1,
        FLD_BODY    = 3'd2,
        FLD_CRC     = 3'd3,
        FLD_CRC_DEL = 3'd4,
        FLD_ACK     = 3'd5,
        FLD_ACK_DEL = 3'd6,
        FLD_EOF     = 3'd7
    } fld_e;

    // Member order fixes the register bit positions 5..0.
    typedef struct packed {
        logic tmr_wrap;
        logic buf_full;
        logic stuff;
        logic crc;
        logic form;
        logic ack;
    } flags_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    function automatic logic in_stuff_zone(input fld_e f);
        return (f == FLD_SOF) || (f == FLD_BODY) || (f == FLD_CRC);
    endfunction

endpackage

// File: rtl/can_stuff_chk.sv
module can_stuff_chk
    import can_flag_pkg::*;
#(
    parameter int RUN_LIMIT = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic rx_bit,
    input  fld_e fld,
    output logic err
);
    localparam int RUN_W = $clog2(RUN_LIMIT + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LIMIT + 1);

    logic [RUN_W-1:0] run_q;
    logic             last_q;
    logic             active;
    logic             same;

    assign active = bit_valid && in_stuff_zone(fld);
    assign same   = (fld != FLD_SOF) && (rx_bit == last_q);
    assign err    = active && same && (run_q >= RUN_W'(RUN_LIMIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= '0;
            last_q <= 1'b1;
        end else if (active) begin
            last_q <= rx_bit;
            if (!same)
                run_q <= RUN_W'(1);
            else if (run_q != RUN_MAX)
                run_q <= run_q + RUN_W'(1);
        end
    end

    // R6: the run counter never passes its saturation value
    p_run_bounded_r6: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_MAX);

    // R6: a start-of-frame bit restarts the run at one
    p_sof_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && fld == FLD_SOF) |=> (run_q == RUN_W'(1)));

endmodule

// File: rtl/can_crc_chk.sv
module can_crc_chk
    import can_flag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_valid,
    input  logic rx_bit,
    input  logic stuff_slot,
    input  fld_e fld,
    output logic err
);
    logic [CRC_W-1:0] rem_q;
    logic             feed;

    assign feed = bit_valid && !stuff_slot && in_stuff_zone(fld);
    assign err  = bit_valid && (fld == FLD_CRC_DEL) && (rem_q != '0);

    always_ff @(posedge clk) begin
        if (rst)
            rem_q <= '0;
        else if (feed)
            rem_q <= crc_step((fld == FLD_SOF) ? '0 : rem_q, rx_bit);
    end

    // R7: a dominant start-of-frame bit leaves a zero remainder
    p_sof_zero_rem_r7: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !stuff_slot && fld == FLD_SOF && !rx_bit) |=> (rem_q == '0));

    // R7: stuff bits never alter the remainder
    p_stuff_skipped_r7: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && stuff_slot) |=> $stable(rem_q));

endmodule

// File: rtl/can_flag_reg.sv
module can_flag_reg
    import can_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  flags_t            ev,
    input  logic              wr,
    input  logic [FLAG_N-1:0] wdata,
    input  logic              tmr_en,
    output flags_t            q,
    output logic              summary
);
    logic [FLAG_N-1:0] clr_mask;
    flags_t            q_n;

    assign clr_mask = wr ? ~wdata : '0;

    always_comb begin
        q_n = flags_t'((q & ~clr_mask) | ev);
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= q_n;
    end

    assign summary = q.buf_full | q.stuff | q.crc | q.form | q.ack
                   | (q.tmr_wrap & tmr_en);

    // R2: a set event is visible on the next edge even under a clear
    for (genvar i = 0; i < FLAG_N; i++) begin : g_chk
        p_set_wins_r2: assert property (@(posedge clk) disable iff (rst)
            ev[i] |=> q[i]);
        p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
            (q[i] && !(wr && !wdata[i])) |=> q[i]);
    end

endmodule

// File: rtl/can_err_irq_unit.sv
module can_err_irq_unit
    import can_flag_pkg::*;
#(
    parameter int TMR_W     = 16,
    parameter int RUN_LIMIT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_valid,
    input  logic             rx_bit,
    input  logic             stuff_slot,
    input  logic [2:0]       fld_code,
    input  logic [TMR_W-1:0] can_timer,
    input  logic             buf_full,
    input  logic             tmr_irq_en,
    input  logic             reg_wr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic             irq
);
    localparam logic [TMR_W-1:0] TMR_TOP = '1;

    fld_e             fld;
    logic [TMR_W-1:0] tmr_prev_q;
    flags_t           ev;
    flags_t           flags;
    logic             summary;
    logic             stuff_err;
    logic             crc_err;
    logic             unused_wr_hi;

    assign fld          = fld_e'(fld_code);
    assign unused_wr_hi = ^reg_wdata[7:6];

    always_ff @(posedge clk) begin
        if (rst)
            tmr_prev_q <= '0;
        else
            tmr_prev_q <= can_timer;
    end

    can_stuff_chk #(.RUN_LIMIT(RUN_LIMIT)) u_stuff (
        .clk       (clk),
        .rst       (rst),
        .bit_valid (bit_valid),
        .rx_bit    (rx_bit),
        .fld       (fld),
        .err       (stuff_err)
    );

    can_crc_chk u_crc (
        .clk        (clk),
        .rst        (rst),
        .bit_valid  (bit_valid),
        .rx_bit     (rx_bit),
        .stuff_slot (stuff_slot),
        .fld        (fld),
        .err        (crc_err)
    );

    always_comb begin
        ev          = '0;
        ev.tmr_wrap = (tmr_prev_q == TMR_TOP) && (can_timer == '0);
        ev.buf_full = buf_full;
        ev.stuff    = stuff_err;
        ev.crc      = crc_err;
        ev.form     = bit_valid && !rx_bit &&
                      ((fld == FLD_CRC_DEL) || (fld == FLD_ACK_DEL) || (fld == FLD_EOF));
        ev.ack      = bit_valid && rx_bit && (fld == FLD_ACK);
    end

    can_flag_reg u_flags (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .wr      (reg_wr),
        .wdata   (reg_wdata[FLAG_N-1:0]),
        .tmr_en  (tmr_irq_en),
        .q       (flags),
        .summary (summary)
    );

    assign reg_rdata = {summary, 1'b0, flags};
    assign irq       = summary;

    // R3: a top-to-zero timer step sets the wrap flag on the next edge
    p_wrap_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (tmr_prev_q == TMR_TOP && can_timer == '0) |=> reg_rdata[5]);

    // R4: with the enable low, a lone wrap flag raises no interrupt
    p_tmr_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (!tmr_irq_en && reg_rdata[4:0] == '0) |-> !irq);

    // R9: a recessive acknowledge slot bit sets the acknowledge flag
    p_ack_sets_r9: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && fld == FLD_ACK && rx_bit) |=> reg_rdata[0]);

    // R8: a dominant end-of-frame bit sets the form flag
    p_form_sets_r8: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && fld == FLD_EOF && !rx_bit) |=> reg_rdata[1]);

    // R1: the reserved position never reads as one
    p_rsvd_low_r1: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_rdata[6]);

endmodule

// File: tb/can_err_irq_unit_tb.sv
module can_err_irq_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [14:0] POLY = 15'h4599;
    // {data[15:0], mode[7:0], expected byte[7:0]}
    // mode 0 clean, 1 bad CRC, 2 recessive ack, 3 dominant EOF bit, 4 no stuffing
    localparam logic [31:0] VECS [8] = '{
        32'h0000_00_00, 32'hA5C3_00_00, 32'h1234_01_84, 32'hFFFF_02_81,
        32'h5A5A_03_82, 32'h03F0_04_88, 32'h0000_01_84, 32'h7E81_02_81
    };

    logic        clk = 0;
    logic        rst = 1;
    logic        bit_valid = 0;
    logic        rx_bit = 1;
    logic        stuff_slot = 0;
    logic [2:0]  fld_code = 0;
    logic [15:0] can_timer = 0;
    logic        buf_full = 0;
    logic        tmr_irq_en = 0;
    logic        reg_wr = 0;
    logic [7:0]  reg_wdata = 0;
    logic [7:0]  reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int run_cnt;
    logic last_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_err_irq_unit u_dut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .rx_bit(rx_bit),
        .stuff_slot(stuff_slot), .fld_code(fld_code), .can_timer(can_timer),
        .buf_full(buf_full), .tmr_irq_en(tmr_irq_en), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [14:0] ref_crc(input logic [14:0] c, input logic b);
        logic [14:0] n;
        n = c << 1;
        if (b != c[14]) n = n ^ POLY;
        return n;
    endfunction

    task automatic put_bit(input logic [2:0] f, input logic b, input logic s);
        @(negedge clk);
        fld_code = f; rx_bit = b; stuff_slot = s; bit_valid = 1;
    endtask

    task automatic tx(input logic [2:0] f, input logic b, input logic st);
        put_bit(f, b, 0);
        if (b == last_b) run_cnt++;
        else begin run_cnt = 1; last_b = b; end
        if (st && run_cnt == 5) begin
            put_bit(f, ~b, 1);
            run_cnt = 1; last_b = ~b;
        end
    endtask

    task automatic send_frame(input logic [15:0] data, input logic [7:0] mode);
        logic [14:0] c;
        logic st;
        c = ref_crc(15'h0, 1'b0);
        for (int i = 15; i >= 0; i--) c = ref_crc(c, data[i]);
        if (mode == 1) c[0] = ~c[0];
        st = (mode != 4);
        run_cnt = 0; last_b = 1;
        tx(3'd1, 1'b0, st);
        for (int i = 15; i >= 0; i--) tx(3'd2, data[i], st);
        for (int i = 14; i >= 0; i--) tx(3'd3, c[i], st);
        put_bit(3'd4, 1'b1, 0);
        put_bit(3'd5, (mode == 2), 0);
        put_bit(3'd6, 1'b1, 0);
        for (int k = 0; k < 7; k++) put_bit(3'd7, !(mode == 3 && k == 3), 0);
        @(negedge clk);
        bit_valid = 0; fld_code = 0; rx_bit = 1; stuff_slot = 0;
    endtask

    task automatic write_reg(input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_wdata = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset byte", reg_rdata, 8'h00);
        chk("R10 reset irq", {7'b0, irq}, 8'h00);

        // R3: a step that skips zero does not count as a wrap
        can_timer = 16'hFFFF; @(negedge clk);
        can_timer = 16'h0001; @(negedge clk);
        chk("R3 no wrap on FFFF->0001", reg_rdata, 8'h00);

        can_timer = 16'hFFFF; @(negedge clk);
        can_timer = 16'h0000; @(negedge clk);
        chk("R3 wrap flag", reg_rdata, 8'h20);
        chk("R4 gated irq low", {7'b0, irq}, 8'h00);
        tmr_irq_en = 1; #1;
        chk("R4 enabled wrap summary", reg_rdata, 8'hA0);
        chk("R10 irq follows summary", {7'b0, irq}, 8'h01);

        write_reg(8'hFF);
        chk("R2 write ones keeps flags, R1 bit6 low", reg_rdata, 8'hA0);
        write_reg(8'hDF);
        chk("R2 clear bit5 only", reg_rdata, 8'h00);

        @(negedge clk); buf_full = 1;
        @(negedge clk); buf_full = 0;
        @(negedge clk);
        chk("R5 buffer flag sticky", reg_rdata, 8'h90);

        @(negedge clk); buf_full = 1; reg_wr = 1; reg_wdata = 8'h00;
        @(negedge clk); buf_full = 0; reg_wr = 0;
        chk("R2 set beats clear", reg_rdata, 8'h90);
        write_reg(8'h00);
        chk("R2 clear all", reg_rdata, 8'h00);
        tmr_irq_en = 0;

        // R6: unstrobed bits and idle-field bits are not examined
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); fld_code = 3'd2; rx_bit = 1; bit_valid = 0;
        end
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); fld_code = 3'd0; rx_bit = 0; bit_valid = 1;
        end
        @(negedge clk); bit_valid = 0; fld_code = 0; rx_bit = 1;
        @(negedge clk);
        chk("R6 gating: no flag", reg_rdata, 8'h00);

        foreach (VECS[v]) begin
            write_reg(8'h00);
            send_frame(VECS[v][31:16], VECS[v][15:8]);
            case (VECS[v][15:8])
                8'd1:    chk("R7 CRC error frame", reg_rdata, VECS[v][7:0]);
                8'd2:    chk("R9 ack error frame", reg_rdata, VECS[v][7:0]);
                8'd3:    chk("R8 form error frame", reg_rdata, VECS[v][7:0]);
                8'd4:    chk("R6 stuff error frame", reg_rdata, VECS[v][7:0]);
                default: chk("R7 clean frame", reg_rdata, VECS[v][7:0]);
            endcase
            chk("R10 irq per frame", {7'b0, irq}, {7'b0, (VECS[v][7:0] != 0)});
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule